// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides, for each received CAN frame identifier, whether one of fourteen message centers should accept it, and which one. Every center supplies an arbitration identifier, a select bit that says whether it takes standard (11-bit) or extended (29-bit) frames, a flag that turns masked comparison on or off, and an enable bit. These come in as ports from the message storage that sits beside the filter. The centers do not have masks of their own. All standard centers share one 11-bit global mask and all extended centers share one 29-bit global mask.

Software reaches the two global masks through a byte-wide register port. The port accepts writes only while the initialization input is high, so a running filter cannot have its masks changed under it. The receive logic presents an identifier, an extended-frame flag and a one-cycle strobe. One clock later the filter reports a hit flag and the 1-based number of the accepting center. When more than one center accepts, the lowest number is reported.

Top module: `can_accept_filter`

## Requirements
- R1: After a synchronous active-low reset, both global masks hold all zeros, every mask register reads 0x00, `hit_o` is 0 and `hit_idx_o` is 0.
- R2: A center whose mask-enable bit is 0 accepts only when the compared identifier bits equal its arbitration bits exactly, whatever the global masks hold.
- R3: A standard center whose mask-enable bit is 1 ignores identifier bit n wherever standard mask bit n is 0, and requires equality wherever that mask bit is 1.
- R4: An extended center whose mask-enable bit is 1 applies the same rule with the 29-bit extended mask. The standard mask has no effect on extended centers, and the extended mask has no effect on standard centers.
- R5: A center accepts only when the frame's extended flag equals its select bit (1 = extended). Standard comparison uses identifier bits 10..0, and bits 28..11 have no effect on it.
- R6: A center whose enable bit is 0 never accepts.
- R7: `hit_idx_o` gives the lowest-numbered accepting center, with centers numbered 1 to 14 (port bit i holds center i+1). When `hit_o` is 0, `hit_idx_o` is 0.
- R8: `hit_o` and `hit_idx_o` are registered. They reflect the frame presented with `frm_valid_i` high at the previous rising edge, and they are 0 after any edge at which `frm_valid_i` was low.
- R9: A write to a mask register takes effect only while `init_i` is 1. Writes made while `init_i` is 0 leave every mask bit unchanged.
- R10: The register map is as follows. Address 0 holds standard mask bits 10..3. Address 1 holds bits 2..0 in data bits 7..5, and its bits 4..0 read 0 and ignore writes. Addresses 2, 3 and 4 hold extended mask bits 28..21, 20..13 and 12..5. Address 5 holds bits 4..0 in data bits 7..3, and its bits 2..0 read 0. Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Software initialization flag; mask writes allowed only when 1 |
| reg_wr_i | input | 1 | Mask register write strobe |
| reg_addr_i | input | 3 | Mask register address |
| reg_wdata_i | input | 8 | Mask register write data |
| reg_rdata_o | output | 8 | Mask register read data (combinational) |
| ctr_arb_i | input | NUM_CTR*29 | Arbitration identifiers; center i+1 in bits [29i+28:29i] |
| ctr_ext_i | input | NUM_CTR | Per-center select: 1 = extended, 0 = standard |
| ctr_mme_i | input | NUM_CTR | Per-center mask enable |
| ctr_en_i | input | NUM_CTR | Per-center enable |
| frm_valid_i | input | 1 | Frame identifier strobe |
| frm_ext_i | input | 1 | Frame carries an extended identifier |
| frm_id_i | input | 29 | Frame identifier (standard in bits 10..0) |
| hit_o | output | 1 | A center accepted the frame |
| hit_idx_o | output | 4 | Accepting center number 1..14, 0 when no hit |

## Verification
The hardest case to reach from the ports is a frame that several centers accept at once, each under a different rule: one by exact match, one through a mask don't-care, and one that would win on priority but is disabled or has the other select. Random identifiers almost never produce this. The bench therefore derives each frame from a chosen center's arbitration value and flips a sparse random set of bits, and it gives several centers identical arbitration values while it walks the enable pattern. The standard space is also swept exhaustively with random upper bits, so that every exact-match center is hit and the bits above 10 are shown to have no effect.

// File: rtl/can_filt_pkg.sv
// Package: shared widths and the mask register address map for the
// CAN acceptance filter. Assumes byte-wide software access.
package can_filt_pkg;
    localparam int STD_W  = 11;
    localparam int EXT_W  = 29;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef logic [EXT_W-1:0] can_id_t;
    typedef logic [STD_W-1:0] std_id_t;

    // Mask register addresses; the byte packing is MSB-aligned.
    typedef enum logic [ADDR_W-1:0] {
        MREG_STD_HI = 3'd0,
        MREG_STD_LO = 3'd1,
        MREG_EXT_B3 = 3'd2,
        MREG_EXT_B2 = 3'd3,
        MREG_EXT_B1 = 3'd4,
        MREG_EXT_B0 = 3'd5
    } mreg_addr_e;
endpackage

// File: rtl/can_mask_regs.sv
// Module: global mask register file. Holds the shared 11-bit standard and
// 29-bit extended masks behind a byte-wide port. Writes land only while
// init_i is high; unused bit positions read 0 and discard writes.
module can_mask_regs
    import can_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    output std_id_t           std_mask_o,
    output can_id_t           ext_mask_o
);
    std_id_t std_mask_q;
    can_id_t ext_mask_q;
    logic    wr_en;

    assign wr_en = wr_i & init_i;

    // Update the addressed mask byte when writes are unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            std_mask_q <= '0;
            ext_mask_q <= '0;
        end else if (wr_en) begin
            case (mreg_addr_e'(addr_i))
                MREG_STD_HI: std_mask_q[10:3]  <= wdata_i;
                MREG_STD_LO: std_mask_q[2:0]   <= wdata_i[7:5];
                MREG_EXT_B3: ext_mask_q[28:21] <= wdata_i;
                MREG_EXT_B2: ext_mask_q[20:13] <= wdata_i;
                MREG_EXT_B1: ext_mask_q[12:5]  <= wdata_i;
                MREG_EXT_B0: ext_mask_q[4:0]   <= wdata_i[7:3];
                default: ;
            endcase
        end
    end

    // Return the addressed byte with unused positions forced to zero.
    always_comb begin
        rdata_o = '0;
        case (mreg_addr_e'(addr_i))
            MREG_STD_HI: rdata_o = std_mask_q[10:3];
            MREG_STD_LO: rdata_o = {std_mask_q[2:0], 5'b0};
            MREG_EXT_B3: rdata_o = ext_mask_q[28:21];
            MREG_EXT_B2: rdata_o = ext_mask_q[20:13];
            MREG_EXT_B1: rdata_o = ext_mask_q[12:5];
            MREG_EXT_B0: rdata_o = {ext_mask_q[4:0], 3'b0};
            default:     rdata_o = '0;
        endcase
    end

    assign std_mask_o = std_mask_q;
    assign ext_mask_o = ext_mask_q;
endmodule

// File: rtl/can_ctr_match.sv
// Module: one message center comparator. Combinational. A center matches
// when enabled, of the same frame type, and every cared-for bit agrees.
// With mask enable low every bit is cared for; standard uses bits 10..0.
module can_ctr_match
    import can_filt_pkg::*;
(
    input  can_id_t frm_id_i,
    input  logic    frm_ext_i,
    input  can_id_t arb_i,
    input  logic    ctr_ext_i,
    input  logic    mme_i,
    input  logic    en_i,
    input  std_id_t std_mask_i,
    input  can_id_t ext_mask_i,
    output logic    match_o
);
    std_id_t std_care;
    can_id_t ext_care;
    logic    std_ok;
    logic    ext_ok;

    // Choose which bits must agree for each identifier width.
    always_comb begin
        std_care = mme_i ? std_mask_i : '1;
        ext_care = mme_i ? ext_mask_i : '1;
    end

    // Compare the cared-for bits and qualify by type and enable.
    always_comb begin
        std_ok  = ((frm_id_i[STD_W-1:0] ^ arb_i[STD_W-1:0]) & std_care) == '0;
        ext_ok  = ((frm_id_i ^ arb_i) & ext_care) == '0;
        match_o = en_i && (frm_ext_i == ctr_ext_i) && (ctr_ext_i ? ext_ok : std_ok);
    end
endmodule

// File: rtl/can_prio_enc.sv
// Module: lowest-index priority encoder. Reports a 1-based index of the
// lowest set request bit, or 0 with any_o low when none is set.
module can_prio_enc #(
    parameter int N     = 14,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i + 1);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/can_accept_filter.sv
// Module: CAN identifier acceptance filter top. NUM_CTR centers compared in
// parallel against one strobed identifier using shared global masks; the
// winning center number is registered one cycle after the strobe.
// Assumes center configuration is held stable by the message storage.
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int  NUM_CTR = 14,
    localparam int IDX_W   = $clog2(NUM_CTR + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_i,
    input  logic                     reg_wr_i,
    input  logic [ADDR_W-1:0]        reg_addr_i,
    input  logic [BYTE_W-1:0]        reg_wdata_i,
    output logic [BYTE_W-1:0]        reg_rdata_o,
    input  logic [NUM_CTR*EXT_W-1:0] ctr_arb_i,
    input  logic [NUM_CTR-1:0]       ctr_ext_i,
    input  logic [NUM_CTR-1:0]       ctr_mme_i,
    input  logic [NUM_CTR-1:0]       ctr_en_i,
    input  logic                     frm_valid_i,
    input  logic                     frm_ext_i,
    input  logic [EXT_W-1:0]         frm_id_i,
    output logic                     hit_o,
    output logic [IDX_W-1:0]         hit_idx_o
);
    std_id_t            std_mask_w;
    can_id_t            ext_mask_w;
    logic [NUM_CTR-1:0] match_w;
    logic               any_w;
    logic [IDX_W-1:0]   idx_w;
    logic               hit_q;
    logic [IDX_W-1:0]   idx_q;

    can_mask_regs u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .rdata_o    (reg_rdata_o),
        .std_mask_o (std_mask_w),
        .ext_mask_o (ext_mask_w)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        can_ctr_match u_match (
            .frm_id_i   (frm_id_i),
            .frm_ext_i  (frm_ext_i),
            .arb_i      (ctr_arb_i[g*EXT_W +: EXT_W]),
            .ctr_ext_i  (ctr_ext_i[g]),
            .mme_i      (ctr_mme_i[g]),
            .en_i       (ctr_en_i[g]),
            .std_mask_i (std_mask_w),
            .ext_mask_i (ext_mask_w),
            .match_o    (match_w[g])
        );
    end

    can_prio_enc #(
        .N     (NUM_CTR),
        .IDX_W (IDX_W)
    ) u_prio (
        .req_i (match_w),
        .any_o (any_w),
        .idx_o (idx_w)
    );

    // Capture the decision for a strobed frame; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
        end else begin
            hit_q <= frm_valid_i & any_w;
            idx_q <= (frm_valid_i & any_w) ? idx_w : '0;
        end
    end

    assign hit_o     = hit_q;
    assign hit_idx_o = idx_q;
endmodule

// File: rtl/can_accept_filter_chk.sv
// Module: property checker for the acceptance filter, bound to the top.
// Registers the per-center enables and selects seen with each strobe so a
// reported winner can be checked against them.
module can_accept_filter_chk
    import can_filt_pkg::*;
#(
    parameter int NUM_CTR = 14,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [BYTE_W-1:0]  reg_rdata_o,
    input logic [NUM_CTR-1:0] ctr_ext_i,
    input logic [NUM_CTR-1:0] ctr_en_i,
    input logic               frm_valid_i,
    input logic               frm_ext_i,
    input logic               hit_o,
    input logic [IDX_W-1:0]   hit_idx_o,
    input std_id_t            std_mask,
    input can_id_t            ext_mask
);
    logic [NUM_CTR-1:0] en_q;
    logic [NUM_CTR-1:0] sel_q;
    logic               fext_q;
    logic               win_en;
    logic               win_sel;

    // Remember the center configuration seen at the strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            sel_q  <= '0;
            fext_q <= 1'b0;
        end else begin
            en_q   <= ctr_en_i;
            sel_q  <= ctr_ext_i;
            fext_q <= frm_ext_i;
        end
    end

    // Look up the remembered settings of the reported winner.
    always_comb begin
        win_en  = 1'b0;
        win_sel = 1'b0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (hit_idx_o == IDX_W'(i + 1)) begin
                win_en  = en_q[i];
                win_sel = sel_q[i];
            end
        end
    end

    assert_idx_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_o |-> hit_idx_o == '0);
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_idx_o >= IDX_W'(1)) && (hit_idx_o <= IDX_W'(NUM_CTR)));
    assert_no_strobe_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid_i |=> !hit_o);
    assert_winner_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> win_en);
    assert_winner_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> win_sel == fext_q);
    assert_mask_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> $stable(std_mask) && $stable(ext_mask));
    assert_unused_std_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr_i == ADDR_W'(1) |-> reg_rdata_o[4:0] == 5'b0);
    assert_unused_ext_bits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr_i == ADDR_W'(5) |-> reg_rdata_o[2:0] == 3'b0);
endmodule

bind can_accept_filter can_accept_filter_chk #(
    .NUM_CTR (NUM_CTR),
    .IDX_W   (IDX_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .ctr_ext_i   (ctr_ext_i),
    .ctr_en_i    (ctr_en_i),
    .frm_valid_i (frm_valid_i),
    .frm_ext_i   (frm_ext_i),
    .hit_o       (hit_o),
    .hit_idx_o   (hit_idx_o),
    .std_mask    (std_mask_w),
    .ext_mask    (ext_mask_w)
);

// File: tb/can_accept_filter_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps the standard identifier space, drives sparse-flip extended
// frames and walks enable patterns, checking against an arithmetic model.
module can_accept_filter_tb_top;
    localparam int NC = 14;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          init;
    logic          wr;
    logic [2:0]    addr;
    logic [7:0]    wdata;
    logic [7:0]    rdata;
    logic [28:0]   c_arb [NC];
    logic [NC*29-1:0] arb_flat;
    logic [NC-1:0] c_ext, c_mme, c_en;
    logic          valid, fext;
    logic [28:0]   fid;
    logic          hit;
    logic [IW-1:0] idx;

    logic [10:0]   m_std;
    logic [28:0]   m_ext;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NC; i++) arb_flat[i*29 +: 29] = c_arb[i];
    end

    can_accept_filter dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init), .reg_wr_i(wr),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .ctr_arb_i(arb_flat), .ctr_ext_i(c_ext), .ctr_mme_i(c_mme),
        .ctr_en_i(c_en), .frm_valid_i(valid), .frm_ext_i(fext),
        .frm_id_i(fid), .hit_o(hit), .hit_idx_o(idx)
    );

    function automatic int exp_idx(logic [28:0] id, logic ext);
        for (int i = 0; i < NC; i++) begin
            if (c_en[i] && c_ext[i] == ext) begin
                if (ext) begin
                    if (((id ^ c_arb[i]) & (c_mme[i] ? m_ext : 29'h1FFFFFFF)) == 0) return i + 1;
                end else begin
                    if (((id[10:0] ^ c_arb[i][10:0]) & (c_mme[i] ? m_std : 11'h7FF)) == 0) return i + 1;
                end
            end
        end
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        if (init) begin
            case (a)
                3'd0: m_std[10:3]  = d;
                3'd1: m_std[2:0]   = d[7:5];
                3'd2: m_ext[28:21] = d;
                3'd3: m_ext[20:13] = d;
                3'd4: m_ext[12:5]  = d;
                3'd5: m_ext[4:0]   = d[7:3];
                default: ;
            endcase
        end
    endtask

    task automatic rd_check(logic [2:0] a, logic [7:0] e, string tag);
        @(negedge clk);
        addr = a;
        #1;
        check(tag, int'(rdata), int'(e));
    endtask

    task automatic send(logic [28:0] id, logic ext, string tag);
        int e;
        @(negedge clk);
        fid = id; fext = ext; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        e = exp_idx(id, ext);
        check(tag, int'(hit), (e != 0) ? 1 : 0);
        check(tag, int'(idx), e);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; init = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
        valid = 1'b0; fext = 1'b0; fid = '0;
        c_ext = '0; c_mme = '0; c_en = '0;
        for (int i = 0; i < NC; i++) c_arb[i] = '0;
        m_std = '0; m_ext = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of outputs and registers
        check("R1 hit", int'(hit), 0);
        check("R1 idx", int'(idx), 0);
        for (int a = 0; a < 6; a++) rd_check(3'(a), 8'h00, "R1 mask reset");

        // R9: writes while locked are discarded
        for (int a = 0; a < 6; a++) wr_reg(3'(a), 8'hFF);
        for (int a = 0; a < 6; a++) rd_check(3'(a), 8'h00, "R9 locked write");

        // R10: layout and unused bits
        init = 1'b1;
        wr_reg(3'd1, 8'hFF); rd_check(3'd1, 8'hE0, "R10 std low byte");
        wr_reg(3'd5, 8'hFF); rd_check(3'd5, 8'hF8, "R10 ext low byte");
        wr_reg(3'd6, 8'hFF); rd_check(3'd6, 8'h00, "R10 addr 6");
        wr_reg(3'd7, 8'hFF); rd_check(3'd7, 8'h00, "R10 addr 7");
        wr_reg(3'd0, 8'hF0); wr_reg(3'd1, 8'hA0);
        wr_reg(3'd2, 8'hC3); wr_reg(3'd3, 8'h5A); wr_reg(3'd4, 8'hF7); wr_reg(3'd5, 8'h68);
        rd_check(3'd0, 8'hF0, "R10 std high");
        rd_check(3'd3, 8'h5A, "R10 ext byte");
        init = 1'b0;
        wr_reg(3'd0, 8'h00);
        wr_reg(3'd2, 8'h00);
        rd_check(3'd0, 8'hF0, "R9 lock after init");
        rd_check(3'd2, 8'hC3, "R9 lock after init");

        // R2 R3 R5: standard centers, exhaustive sweep with random upper bits
        for (int i = 0; i < NC; i++) c_arb[i] = 29'($urandom);
        c_ext = '0;
        c_mme = 14'b01010101010101;
        c_en  = 14'b11111111011111;
        for (int v = 0; v < 2048; v++) begin
            logic [28:0] id;
            id = {18'($urandom), 11'(v)};
            send(id, 1'b0, "R2 R3 R5 std sweep");
        end
        for (int v = 0; v < 64; v++)
            send(c_arb[v % NC], 1'b1, "R5 ext frame vs std centers");

        // R4: mixed centers, extended frames by sparse flips
        for (int i = 0; i < NC; i++) c_arb[i] = 29'($urandom);
        c_ext = 14'b11110111101111;
        c_mme = 14'b00111100110011;
        c_en  = '1;
        for (int n = 0; n < 3000; n++) begin
            int k;
            logic [28:0] id;
            logic e;
            k = int'($urandom % NC);
            id = c_arb[k] ^ (29'($urandom) & 29'($urandom) & 29'($urandom));
            e = (n % 5) != 0;
            send(id, e, "R4 R5 mixed frames");
        end

        // R6 R7: identical centers, walking enables
        for (int i = 0; i < NC; i++) c_arb[i] = 29'h0ABCDEF1;
        c_ext = '0; c_mme = '0;
        for (int p = 0; p <= NC; p++) begin
            c_en = (p == NC) ? '0 : (14'h3FFF << p);
            send(29'h0ABCDEF1, 1'b0, "R6 R7 priority");
            check("R7 lowest", int'(idx), (p == NC) ? 0 : p + 1);
        end
        c_en = 14'b10000000000100;
        send(29'h0ABCDEF1, 1'b0, "R6 R7 sparse enables");
        check("R7 pick center 3", int'(idx), 3);

        // R8: no strobe means no hit, and the flag drops after one cycle
        c_en = '1;
        @(negedge clk);
        fid = 29'h0ABCDEF1; fext = 1'b0; valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            check("R8 no strobe", int'(hit), 0);
        end
        send(29'h0ABCDEF1, 1'b0, "R8 strobe");
        check("R8 one-cycle hit", int'(hit), 1);
        @(negedge clk);
        check("R8 cleared", int'(hit), 0);
        check("R8 idx cleared", int'(idx), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule